// File: doc/BRIEF.md
# Memory-Mapped Leaky Integrate-and-Fire Neuron

This peripheral holds a single leaky integrate-and-fire neuron behind an AXI4-Lite slave port. A host programs the input current, the resting potential, the membrane time constant and the capacitance as signed Q8.8 words (16 bits with 8 fraction bits, carried in the low half of each 32-bit bus word). A control word enables or stops updates and can hold the neuron in reset. Spike activity is read back through a clear-on-read counter, and an interrupt line stays high while spikes are waiting to be read.

Each pulse on the `tick` input starts one explicit Euler step of dv/dt = -(v - E_rest)/tau + I/C. Two sequential dividers run side by side to form both quotients. The derivative is then scaled by the fixed step `DT_Q` and added to the membrane potential, with every intermediate value clamped to the Q8.8 range. When the new potential rises above -50.0, the neuron fires and the potential is set back to -65.0 instead. The host restarts the neuron by writing 0x02 to the control word and then 0x01.

Top module: `lif_mmio_periph`

## Requirements
- R1: A write is accepted in the cycle where awvalid and wvalid are both high and no write response is pending. bvalid rises on the next cycle and stays high until bready. A read is accepted when arvalid is high and no read response is pending. rvalid and rdata appear on the next cycle and stay unchanged until rready. bresp and rresp are always OKAY (2'b00).
- R2: Word offsets in the 0x100-byte window (address bits [7:2] decoded, bits [1:0] ignored): 0x00 control, 0x04 input current, 0x08 spike count, 0x0C resting potential, 0x10 membrane time constant, 0x14 capacitance.
- R3: The control word reads back bits [1:0], with every other bit zero. Reads of the current, the three parameters and any unmapped offset return zero. Writes to the spike count offset and to unmapped offsets change nothing.
- R4: Each value register takes wdata[15:0] as signed Q8.8. After rst_n the values are: control 0, current 0, resting potential -65.0 (0xBF00), time constant 10.0 (0x0A00), capacitance 1.0 (0x0100), spike count 0, membrane potential -65.0.
- R5: A tick that is accepted while the neuron is idle computes the new potential as v' = sat(v + sat((d * DT_Q) >>> 8)). Here d = sat(sat(I*256/C) - sat(sat(v - E_rest)*256/tau)), sat clamps to [-32768, 32767], division truncates toward zero, and any division by zero yields 0.
- R6: When v' > -50.0 (0xCE00, as a signed compare), a spike is emitted and the potential becomes -65.0 (0xBF00) instead of v'.
- R7: Ticks take effect only while control bit 0 (enable) is 1 and control bit 1 (hold) is 0. While hold is 1, the potential is held at -65.0, any update in progress is abandoned and the spike count is cleared.
- R8: With default parameters, a tick 8 cycles after an accepted tick is accepted. Any tick that arrives during the 7 cycles after an accepted tick is ignored.
- R9: Each spike increments the count, which saturates at 2^CNT_W-1 (255 by default). A read of offset 0x08 returns the count zero-extended and clears it.
- R10: irq is high exactly when the spike count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle update request |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Spike pending interrupt |

## Verification
The embedded properties check the following on every cycle: that a pending bus response holds steady, that the two dividers finish together with single-cycle done pulses, that a spike always leaves the potential at -65.0, that hold forces the reset potential, that an idle neuron without an accepted tick keeps its potential, and how the counter steps up or clears. The following can only be shown by the bench's scenarios: the exact Euler arithmetic with saturation and truncating division, the firing threshold over random parameter sets, the register map and its write-only and unmapped behaviour, the cycle window in which ticks are dropped, and counter saturation. The bench shows these by comparing spike counts read over the bus with a reference model.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int QW = 16;
    localparam int QF = 8;

    typedef logic signed [QW-1:0] q_t;

    localparam q_t V_THRESH = -16'sd12800;
    localparam q_t V_RESET  = -16'sd16640;

    localparam q_t RST_REST = -16'sd16640;
    localparam q_t RST_TAU  = 16'sd2560;
    localparam q_t RST_CAP  = 16'sd256;

    localparam int IDX_CTRL = 0;
    localparam int IDX_CUR  = 1;
    localparam int IDX_SPK  = 2;
    localparam int IDX_REST = 3;
    localparam int IDX_TAU  = 4;
    localparam int IDX_CAP  = 5;

    typedef enum logic [0:0] {NS_IDLE, NS_DIV} nstate_e;

    function automatic q_t sat_q(input logic signed [39:0] x);
        if (x > 40'sd32767)
            return 16'sh7FFF;
        else if (x < -40'sd32768)
            return 16'sh8000;
        else
            return q_t'(x[QW-1:0]);
    endfunction

endpackage

// File: rtl/lif_qdiv.sv
module lif_qdiv
    import lif_pkg::*;
#(
    parameter int STEP_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  q_t   dividend,
    input  q_t   divisor,
    output logic done,
    output q_t   quot
);
    localparam int MAG_W = QW + QF;
    localparam int NSTEP = (MAG_W + STEP_BITS - 1) / STEP_BITS;
    localparam int PAD_W = NSTEP * STEP_BITS;
    localparam int CW    = $clog2(NSTEP + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             neg;
        logic             zero;
        logic [CW-1:0]    cnt;
        logic [QW:0]      rem;
        logic [PAD_W-1:0] shf;
        logic [PAD_W-1:0] quo;
        logic [QW-1:0]    dsr;
    } div_s;

    localparam div_s DIV_RST = '0;

    div_s div_q, div_d;

    always_comb begin
        logic [QW:0]      r;
        logic [PAD_W-1:0] s;
        logic [PAD_W-1:0] qq;
        logic [QW-1:0]    mag_n;
        logic [QW-1:0]    mag_d;
        div_d      = div_q;
        div_d.done = 1'b0;
        r     = div_q.rem;
        s     = div_q.shf;
        qq    = div_q.quo;
        mag_n = dividend[QW-1] ? (~dividend + 1'b1) : dividend;
        mag_d = divisor[QW-1]  ? (~divisor + 1'b1)  : divisor;
        if (start) begin
            div_d.busy = 1'b1;
            div_d.cnt  = '0;
            div_d.neg  = dividend[QW-1] ^ divisor[QW-1];
            div_d.zero = (divisor == '0);
            div_d.dsr  = mag_d;
            div_d.rem  = '0;
            div_d.quo  = '0;
            div_d.shf  = PAD_W'({mag_n, {QF{1'b0}}});
        end else if (div_q.busy) begin
            for (int i = 0; i < STEP_BITS; i++) begin
                r = {r[QW-1:0], s[PAD_W-1]};
                s = {s[PAD_W-2:0], 1'b0};
                if (r >= {1'b0, div_q.dsr}) begin
                    r  = r - {1'b0, div_q.dsr};
                    qq = {qq[PAD_W-2:0], 1'b1};
                end else begin
                    qq = {qq[PAD_W-2:0], 1'b0};
                end
            end
            div_d.rem = r;
            div_d.shf = s;
            div_d.quo = qq;
            div_d.cnt = div_q.cnt + 1'b1;
            if (div_q.cnt == CW'(NSTEP - 1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= DIV_RST;
        else
            div_q <= div_d;
    end

    always_comb begin
        if (div_q.zero)
            quot = '0;
        else if (!div_q.neg)
            quot = (div_q.quo > PAD_W'(32767)) ? 16'sh7FFF : q_t'(div_q.quo[QW-1:0]);
        else
            quot = (div_q.quo > PAD_W'(32768)) ? 16'sh8000 : q_t'(-div_q.quo[QW-1:0]);
    end

    assign done = div_q.done;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.done |=> !div_q.done);

endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
    import lif_pkg::*;
#(
    parameter q_t DT_Q      = 16'sh0080,
    parameter int STEP_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic hold,
    input  q_t   i_cur,
    input  q_t   e_rest,
    input  q_t   tau,
    input  q_t   cap,
    output logic spike
);
    typedef struct packed {
        nstate_e st;
        q_t      v;
        logic    spike;
    } nrn_s;

    localparam nrn_s NRN_RST = '{st: NS_IDLE, v: V_RESET, spike: 1'b0};

    nrn_s nrn_q, nrn_d;

    logic go;
    logic done_leak, done_drive;
    q_t   leak_q8, drive_q8, diff;

    assign go   = (nrn_q.st == NS_IDLE) && tick && en && !hold;
    assign diff = sat_q(40'(nrn_q.v) - 40'(e_rest));

    lif_qdiv #(.STEP_BITS(STEP_BITS)) u_div_leak (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .dividend (diff),
        .divisor  (tau),
        .done     (done_leak),
        .quot     (leak_q8)
    );

    lif_qdiv #(.STEP_BITS(STEP_BITS)) u_div_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go),
        .dividend (i_cur),
        .divisor  (cap),
        .done     (done_drive),
        .quot     (drive_q8)
    );

    always_comb begin
        q_t                 deriv;
        q_t                 stepv;
        q_t                 vnext;
        logic signed [39:0] prod;
        nrn_d       = nrn_q;
        nrn_d.spike = 1'b0;
        deriv = sat_q(40'(drive_q8) - 40'(leak_q8));
        prod  = 40'(deriv) * 40'(DT_Q);
        stepv = sat_q(prod >>> QF);
        vnext = sat_q(40'(nrn_q.v) + 40'(stepv));
        if (hold) begin
            nrn_d.st = NS_IDLE;
            nrn_d.v  = V_RESET;
        end else begin
            case (nrn_q.st)
                NS_IDLE: if (go) nrn_d.st = NS_DIV;
                NS_DIV: begin
                    if (done_leak) begin
                        nrn_d.st = NS_IDLE;
                        if (vnext > V_THRESH) begin
                            nrn_d.v     = V_RESET;
                            nrn_d.spike = 1'b1;
                        end else begin
                            nrn_d.v = vnext;
                        end
                    end
                end
                default: nrn_d.st = NS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            nrn_q <= NRN_RST;
        else
            nrn_q <= nrn_d;
    end

    assign spike = nrn_q.spike;

    a_r8_div_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        done_leak == done_drive);
    a_r6_spike_resets_v: assert property (@(posedge clk) disable iff (!rst_n)
        nrn_q.spike |-> nrn_q.v == V_RESET);
    a_r7_hold_forces_rest: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> nrn_q.v == V_RESET);
    a_r5_idle_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
        (nrn_q.st == NS_IDLE && !(tick && en) && !hold) |=> $stable(nrn_q.v));

endmodule

// File: rtl/lif_regs.sv
module lif_regs
    import lif_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    input  logic             spike,
    output logic             en,
    output logic             hold,
    output q_t               i_cur,
    output q_t               e_rest,
    output q_t               tau,
    output q_t               cap,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [1:0]       ctrl;
        q_t               cur;
        q_t               rest;
        q_t               tau;
        q_t               cap;
        logic [CNT_W-1:0] cnt;
    } reg_s;

    localparam reg_s REG_RST = '{ctrl: 2'b00, cur: '0, rest: RST_REST,
                                 tau: RST_TAU, cap: RST_CAP, cnt: '0};

    reg_s reg_q, reg_d;
    logic rd_clr;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[31:16];
    assign rd_clr       = rd_en && (rd_idx == IDX_W'(IDX_SPK));

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            case (wr_idx)
                IDX_W'(IDX_CTRL): reg_d.ctrl = wr_data[1:0];
                IDX_W'(IDX_CUR):  reg_d.cur  = q_t'(wr_data[QW-1:0]);
                IDX_W'(IDX_REST): reg_d.rest = q_t'(wr_data[QW-1:0]);
                IDX_W'(IDX_TAU):  reg_d.tau  = q_t'(wr_data[QW-1:0]);
                IDX_W'(IDX_CAP):  reg_d.cap  = q_t'(wr_data[QW-1:0]);
                default: ;
            endcase
        end
        if (reg_q.ctrl[1])
            reg_d.cnt = '0;
        else if (rd_clr)
            reg_d.cnt = spike ? CNT_W'(1) : '0;
        else if (spike && reg_q.cnt != CNT_MAX)
            reg_d.cnt = reg_q.cnt + 1'b1;
    end

    always_comb begin
        case (rd_idx)
            IDX_W'(IDX_CTRL): rd_data = {30'b0, reg_q.ctrl};
            IDX_W'(IDX_SPK):  rd_data = 32'(reg_q.cnt);
            default:          rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= REG_RST;
        else
            reg_q <= reg_d;
    end

    assign en     = reg_q.ctrl[0];
    assign hold   = reg_q.ctrl[1];
    assign i_cur  = reg_q.cur;
    assign e_rest = reg_q.rest;
    assign tau    = reg_q.tau;
    assign cap    = reg_q.cap;
    assign irq    = (reg_q.cnt != '0);

    a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && !rd_clr && !reg_q.ctrl[1] && reg_q.cnt != CNT_MAX)
            |=> reg_q.cnt == $past(reg_q.cnt) + 1'b1);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !spike) |=> reg_q.cnt == '0);
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.cnt == CNT_MAX && !rd_clr && !reg_q.ctrl[1]) |=> reg_q.cnt == CNT_MAX);

endmodule

// File: rtl/lif_axil_port.sv
module lif_axil_port #(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [31:0]       rd_data
);
    typedef struct packed {
        logic        bvalid;
        logic        rvalid;
        logic [31:0] rdata;
    } bus_s;

    bus_s bus_q, bus_d;
    logic aw_go, ar_go;
    logic unused_lsb;

    assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};
    assign aw_go      = awvalid && wvalid && !bus_q.bvalid;
    assign ar_go      = arvalid && !bus_q.rvalid;

    always_comb begin
        bus_d = bus_q;
        if (bus_q.bvalid && bready) bus_d.bvalid = 1'b0;
        if (aw_go)                  bus_d.bvalid = 1'b1;
        if (bus_q.rvalid && rready) bus_d.rvalid = 1'b0;
        if (ar_go) begin
            bus_d.rvalid = 1'b1;
            bus_d.rdata  = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_q <= '0;
        else
            bus_q <= bus_d;
    end

    assign awready = aw_go;
    assign wready  = aw_go;
    assign arready = ar_go;
    assign bvalid  = bus_q.bvalid;
    assign rvalid  = bus_q.rvalid;
    assign rdata   = bus_q.rdata;
    assign wr_en   = aw_go;
    assign wr_idx  = awaddr[ADDR_W-1:2];
    assign rd_en   = ar_go;
    assign rd_idx  = araddr[ADDR_W-1:2];

    a_r1_bresp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q.bvalid && !bready) |=> bus_q.bvalid);
    a_r1_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q.rvalid && !rready) |=> bus_q.rvalid && $stable(bus_q.rdata));

endmodule

// File: rtl/lif_mmio_periph.sv
module lif_mmio_periph
    import lif_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CNT_W     = 8,
    parameter int STEP_BITS = 4,
    parameter q_t DT_Q      = 16'sh0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic             wr_en, rd_en, spike, en, hold;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [31:0]      rd_data;
    q_t               i_cur, e_rest, tau, cap;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    lif_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    lif_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (s_wdata),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .spike   (spike),
        .en      (en),
        .hold    (hold),
        .i_cur   (i_cur),
        .e_rest  (e_rest),
        .tau     (tau),
        .cap     (cap),
        .irq     (irq)
    );

    lif_neuron #(.DT_Q(DT_Q), .STEP_BITS(STEP_BITS)) u_neuron (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (en),
        .hold   (hold),
        .i_cur  (i_cur),
        .e_rest (e_rest),
        .tau    (tau),
        .cap    (cap),
        .spike  (spike)
    );

    a_r10_irq_tracks_spike: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && !hold) |=> irq);

endmodule

// File: tb/lif_mmio_periph_bench.sv
module lif_mmio_periph_bench;

    localparam int DT = 128;
    localparam int CMAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int n_chk = 0, n_fail = 0, bus_err = 0;
    bit finished = 0;

    int m_v, m_el, m_tau, m_cap, m_cur, m_cnt;

    always #10 clk = ~clk;

    lif_mmio_periph u_lif_mmio_periph (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .irq(irq)
    );

    function automatic int sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    function automatic int mdiv(int a, int b);
        if (b == 0) return 0;
        return sat16((longint'(a) * 256) / b);
    endfunction

    task automatic model_tick();
        int qa, qb, d, st, vn;
        qa = mdiv(sat16(m_v - m_el), m_tau);
        qb = mdiv(m_cur, m_cap);
        d  = sat16(qb - qa);
        st = sat16((longint'(d) * DT) >>> 8);
        vn = sat16(m_v + st);
        if (vn > -12800) begin
            m_v = -16640;
            if (m_cnt < CMAX) m_cnt++;
        end else begin
            m_v = vn;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input int d);
        @(negedge clk);
        awaddr = a; awvalid = 1'b1; wdata = 32'(d); wvalid = 1'b1; bready = 1'b1;
        #1;
        if (!awready || !wready) bus_err++;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        if (!bvalid || bresp != 2'b00) bus_err++;
        @(negedge clk);
        bready = 1'b0;
        if (bvalid) bus_err++;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1; rready = 1'b1;
        #1;
        if (!arready) bus_err++;
        @(negedge clk);
        arvalid = 1'b0;
        d = rdata;
        if (!rvalid || rresp != 2'b00) bus_err++;
        @(negedge clk);
        rready = 1'b0;
        if (rvalid) bus_err++;
    endtask

    task automatic pulse(input int gap);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic restart();
        bus_wr(8'h00, 2);
        bus_wr(8'h00, 1);
        m_v = -16640; m_cnt = 0;
    endtask

    task automatic set_params(input int el, input int tau, input int cap, input int cur);
        m_el = el; m_tau = tau; m_cap = cap; m_cur = cur;
        bus_wr(8'h0C, el); bus_wr(8'h10, tau); bus_wr(8'h14, cap); bus_wr(8'h04, cur);
    endtask

    task automatic run_ticks(input int n, input string tag);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            pulse(10);
            model_tick();
        end
        chk(irq == (m_cnt != 0), {tag, " R10 irq"}, irq, m_cnt != 0);
        bus_rd(8'h08, d);
        chk(d == 32'(m_cnt), {tag, " spikes"}, d, m_cnt);
        m_cnt = 0;
        chk(irq == 1'b0, {tag, " R10 irq after read"}, irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1..all: actual=hang expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        m_v = -16640; m_cnt = 0; m_el = -16640; m_tau = 2560; m_cap = 256; m_cur = 0;

        // R4 / R9 / R10: reset state
        bus_rd(8'h00, d); chk(d == 0, "R4 ctrl reset", d, 0);
        bus_rd(8'h08, d); chk(d == 0, "R9 count reset", d, 0);
        chk(irq == 1'b0, "R10 irq reset", irq, 0);

        // R3: control readback masks upper bits
        bus_wr(8'h00, 32'hFFFF_FFFE);
        bus_rd(8'h00, d); chk(d == 2, "R3 ctrl readback", d, 2);
        bus_wr(8'h00, 0);

        // R3: write-only and unmapped read as zero
        bus_wr(8'h3C, 32'h1234);
        bus_rd(8'h04, d); chk(d == 0, "R3 current reads zero", d, 0);
        bus_rd(8'h10, d); chk(d == 0, "R3 param reads zero", d, 0);
        bus_rd(8'h3C, d); chk(d == 0, "R3 unmapped reads zero", d, 0);
        bus_rd(8'hFC, d); chk(d == 0, "R3 top of window zero", d, 0);

        // R4: default parameters with only current programmed
        bus_wr(8'h00, 1);
        m_cur = 5120; bus_wr(8'h04, m_cur);
        run_ticks(10, "R4 R5 defaults");

        // R2 R5 R6: random parameter sets
        for (int t = 0; t < 10; t++) begin
            int el, tau, cap, cur;
            if (t < 8) begin
                el  = -20480 + int'($urandom % 10240);
                tau = 256 + int'($urandom % 5120);
                cap = 128 + int'($urandom % 1024);
                cur = int'($urandom % 15360) - 5120;
            end else begin
                el  = int'($signed(16'($urandom)));
                tau = int'($signed(16'($urandom)));
                cap = int'($signed(16'($urandom)));
                cur = int'($signed(16'($urandom)));
            end
            restart();
            set_params(el, tau, cap, cur);
            run_ticks(5 + int'($urandom % 16), "R2 R5 R6 random");
        end

        // R5: divide by zero yields zero quotients
        restart();
        set_params(-16640, 0, 0, 32767);
        run_ticks(6, "R5 div by zero");
        set_params(0, 0, 256, 2560);
        run_ticks(6, "R5 tau zero");

        // R7: enable low ignores ticks
        restart();
        set_params(-16640, 2560, 256, 32767);
        bus_wr(8'h00, 0);
        for (int i = 0; i < 4; i++) pulse(10);
        bus_rd(8'h08, d); chk(d == 0, "R7 disabled ignores ticks", d, 0);

        // R7: hold ignores ticks
        bus_wr(8'h00, 3);
        for (int i = 0; i < 4; i++) pulse(10);
        bus_rd(8'h08, d); chk(d == 0, "R7 hold ignores ticks", d, 0);

        // R7: restart clears a pending count
        bus_wr(8'h00, 1);
        pulse(12); pulse(12);
        bus_wr(8'h00, 2);
        bus_rd(8'h08, d); chk(d == 0, "R7 hold clears count", d, 0);
        bus_wr(8'h00, 1);

        // R8: tick inside update window dropped
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (15) @(negedge clk);
        bus_rd(8'h08, d); chk(d == 1, "R8 busy tick ignored", d, 1);

        // R8: tick 8 cycles later accepted
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (7) @(negedge clk);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (15) @(negedge clk);
        bus_rd(8'h08, d); chk(d == 2, "R8 next tick accepted", d, 2);

        // R3: write to spike count dropped
        pulse(12); pulse(12);
        bus_wr(8'h08, 0);
        bus_rd(8'h08, d); chk(d == 2, "R3 count write dropped", d, 2);

        // R9: saturation then clear
        for (int i = 0; i < 260; i++) pulse(9);
        chk(irq == 1'b1, "R10 irq with count", irq, 1);
        bus_rd(8'h08, d); chk(d == CMAX, "R9 count saturates", d, CMAX);
        bus_rd(8'h08, d); chk(d == 0, "R9 read clears", d, 0);

        // R1: read data held while rready low
        @(negedge clk); araddr = 8'h00; arvalid = 1'b1; rready = 1'b0;
        @(negedge clk); arvalid = 1'b0; d0 = rdata;
        repeat (3) @(negedge clk);
        chk(rvalid == 1'b1 && rdata == d0 && d0 == 1, "R1 rdata held", rdata, 1);
        rready = 1'b1;
        @(negedge clk); rready = 1'b0;
        chk(rvalid == 1'b0, "R1 rvalid released", rvalid, 0);
        chk(bus_err == 0, "R1 handshake and OKAY", bus_err, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule